// File: doc/BRIEF.md
# Atomic Line Store Requester

This block issues one indivisible 64-byte store to a memory-mapped target for a core. A request carries a line address, eight 64-bit data words, the memory attributes of the target page (memory type plus inner and outer cacheability), a variant code and a destination register index. The block first checks the alignment and the attributes. A request that fails the check comes back at once with a fault code, and nothing goes out on the write channel.

A request that passes goes out as a single locked burst of eight beats. The block then waits for the target's completion, which carries a 64-bit status word. Depending on the variant, the status is handed back with a write-back flag and destination index, or it is dropped. If no completion arrives within a parameterised number of cycles, the block answers with the "atomic line store unsupported" status. Only one request is in flight at a time.

Top module: `atomic_line_store`

## Requirements
- R1: After reset, `req_ready` is 1 and `wr_valid`, `cpl_ready` and `rsp_valid` are 0.
- R2: For a request that passes the checks, exactly eight beats are sent. Beat i carries `req_data[64*i+63:64*i]` at address `{req_addr[ADDR_W-1:6], i[2:0], 3'b000}`, in ascending order i = 0..7. `wr_first` is 1 on beat 0 only, `wr_last` is 1 on beat 7 only, and `wr_lock` is 1 on every beat.
- R3: While `wr_valid` is 1 and `wr_ready` is 0, the beat's address and data stay unchanged. No beat is sent beyond the eighth.
- R4: An aligned request with `req_memtype`=1 (normal memory) and `req_inner`≠0 or `req_outer`≠0 (0 means non-cacheable) is answered in the cycle after acceptance with `rsp_fault`=1. No beat is sent.
- R5: With `req_memtype`=0 (device), every cacheability value is allowed. Normal memory with both attributes at 0 is allowed as well.
- R6: A request with `req_addr[5:0]`≠0 is answered in the cycle after acceptance with `rsp_fault`=2, and no beat is sent. This alignment fault takes precedence over the fault in R4.
- R7: `cpl_ready` rises only after the final beat is accepted. A completion accepted while `cpl_ready` is 1 ends the wait, and its status (including 0, 1 and all ones) is passed on unchanged. The response appears in the cycle after the completion.
- R8: Variant codes 1 and 2 return the status: `rsp_wb`=1, `rsp_dst`=`req_dst`, `rsp_status`=status. Codes 0 and 3 drop it: `rsp_wb`=0, `rsp_dst`=0, `rsp_status`=0. A faulted response always has `rsp_wb`=0.
- R9: `req_ready` is 0 from the acceptance of a request until its response has been taken with `rsp_ready`.
- R10: If no completion has arrived by the TMO_CYCLES-th cycle after the last beat, the status becomes all ones with fault 0, and the response appears in cycle TMO_CYCLES+1. A completion in cycle TMO_CYCLES is still taken.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | ADDR_W | Line address |
| req_data | input | 512 | Eight 64-bit words, word i at bits 64i |
| req_memtype | input | 1 | 0 device, 1 normal |
| req_inner | input | 2 | Inner cacheability, 0 non-cacheable |
| req_outer | input | 2 | Outer cacheability, 0 non-cacheable |
| req_variant | input | 2 | 1,2 return status; 0,3 drop it |
| req_dst | input | DST_W | Destination register index |
| wr_valid | output | 1 | Beat valid |
| wr_ready | input | 1 | Beat accepted |
| wr_addr | output | ADDR_W | Beat byte address |
| wr_data | output | 64 | Beat data |
| wr_first | output | 1 | First beat of the burst |
| wr_last | output | 1 | Last beat of the burst |
| wr_lock | output | 1 | Burst is indivisible |
| cpl_valid | input | 1 | Completion present |
| cpl_ready | output | 1 | Waiting for completion |
| cpl_status | input | 64 | Completion status word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 2 | 0 none, 1 cacheable normal, 2 misaligned |
| rsp_wb | output | 1 | Status is to be written back |
| rsp_dst | output | DST_W | Destination register index |
| rsp_status | output | 64 | Status word or 0 |

## Verification
The bench runs every combination of memory type, inner and outer cacheability and variant code on aligned lines. This separates the faulting attribute combinations from the allowed ones, and the write-back variants from the dropping ones. Completion statuses rotate through 0, 1, all ones and an arbitrary word, which tells the rejected case apart from the unsupported case. Alternating beat backpressure shows that order and contents survive stalls. Separate runs cover misalignment alone and combined with a cacheable attribute, a completion in the final allowed cycle, and a missing completion under both kinds of variant.

// File: rtl/als_pkg.sv
package als_pkg;
    localparam int LINE_BYTES = 64;
    localparam int BEAT_W     = 64;
    localparam int BEATS      = LINE_BYTES * 8 / BEAT_W;
    localparam int LINE_W     = BEATS * BEAT_W;
    localparam int LINE_OFF   = $clog2(LINE_BYTES);

    localparam logic [1:0]        CACHE_NONE   = 2'd0;
    localparam logic [BEAT_W-1:0] ST_NO_ATOMIC = '1;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_EXCL  = 2'd1,
        FLT_ALIGN = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE, S_SEND, S_WAIT, S_RESP
    } state_e;

    function automatic logic variant_keeps(input logic [1:0] v);
        return (v == 2'd1) || (v == 2'd2);
    endfunction
endpackage

// File: rtl/als_attr_check.sv
module als_attr_check
    import als_pkg::*;
(
    input  logic [LINE_OFF-1:0] addr_low,
    input  logic                memtype,
    input  logic [1:0]          inner,
    input  logic [1:0]          outer,
    output fault_e              fault
);
    always_comb begin
        if (addr_low != '0)
            fault = FLT_ALIGN;
        else if (memtype && ((inner != CACHE_NONE) || (outer != CACHE_NONE)))
            fault = FLT_EXCL;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/als_beat_seq.sv
module als_beat_seq
    import als_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [ADDR_W-LINE_OFF-1:0] line_addr,
    input  logic [LINE_W-1:0]          line_data,
    input  logic                       wr_ready,
    output logic                       wr_valid,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [BEAT_W-1:0]          wr_data,
    output logic                       wr_first,
    output logic                       wr_last,
    output logic                       wr_lock,
    output logic                       done
);
    localparam int IDX_W = $clog2(BEATS);
    localparam int OFF_W = LINE_OFF - IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    logic [BEAT_W-1:0] words [BEATS];
    logic              busy_q;
    logic [IDX_W-1:0]  idx_q;

    for (genvar g = 0; g < BEATS; g++) begin : g_word
        assign words[g] = line_data[g*BEAT_W +: BEAT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q && wr_ready) begin
            if (idx_q == LAST_IDX)
                busy_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign wr_valid = busy_q;
    assign wr_data  = words[idx_q];
    assign wr_addr  = {line_addr, idx_q, {OFF_W{1'b0}}};
    assign wr_first = busy_q && (idx_q == '0);
    assign wr_last  = busy_q && (idx_q == LAST_IDX);
    assign wr_lock  = busy_q;
    assign done     = busy_q && wr_ready && (idx_q == LAST_IDX);

    a_r3_beat_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

    a_r3_no_ninth_beat: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && wr_last) |=> !wr_valid);
endmodule

// File: rtl/als_cpl_timer.sv
module als_cpl_timer #(
    parameter int TMO_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hit,
    output logic expire
);
    localparam int CNT_W = $clog2(TMO_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && !hit && (cnt_q == CNT_LAST);

    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= CNT_LAST));
endmodule

// File: rtl/atomic_line_store.sv
module atomic_line_store
    import als_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DST_W      = 5,
    parameter int TMO_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [511:0]      req_data,
    input  logic              req_memtype,
    input  logic [1:0]        req_inner,
    input  logic [1:0]        req_outer,
    input  logic [1:0]        req_variant,
    input  logic [DST_W-1:0]  req_dst,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [63:0]       wr_data,
    output logic              wr_first,
    output logic              wr_last,
    output logic              wr_lock,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [63:0]       cpl_status,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_fault,
    output logic              rsp_wb,
    output logic [DST_W-1:0]  rsp_dst,
    output logic [63:0]       rsp_status
);
    state_e                     state_q;
    fault_e                     chk_fault;
    fault_e                     fault_q;
    logic [ADDR_W-LINE_OFF-1:0] line_q;
    logic [LINE_W-1:0]          data_q;
    logic [1:0]                 var_q;
    logic [DST_W-1:0]           dst_q;
    logic [BEAT_W-1:0]          status_q;
    logic                       accept, seq_done, expire, keep;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;

    als_attr_check u_check (
        .addr_low (req_addr[LINE_OFF-1:0]),
        .memtype  (req_memtype),
        .inner    (req_inner),
        .outer    (req_outer),
        .fault    (chk_fault)
    );

    als_beat_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && (chk_fault == FLT_NONE)),
        .line_addr (line_q),
        .line_data (data_q),
        .wr_ready  (wr_ready),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_first  (wr_first),
        .wr_last   (wr_last),
        .wr_lock   (wr_lock),
        .done      (seq_done)
    );

    als_cpl_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == S_WAIT),
        .hit    (cpl_valid),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            fault_q  <= FLT_NONE;
            line_q   <= '0;
            data_q   <= '0;
            var_q    <= '0;
            dst_q    <= '0;
            status_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (accept) begin
                    line_q   <= req_addr[ADDR_W-1:LINE_OFF];
                    data_q   <= req_data;
                    var_q    <= req_variant;
                    dst_q    <= req_dst;
                    fault_q  <= chk_fault;
                    status_q <= '0;
                    state_q  <= (chk_fault == FLT_NONE) ? S_SEND : S_RESP;
                end
                S_SEND: if (seq_done) state_q <= S_WAIT;
                S_WAIT: begin
                    if (cpl_valid) begin
                        status_q <= cpl_status;
                        state_q  <= S_RESP;
                    end else if (expire) begin
                        status_q <= ST_NO_ATOMIC;
                        state_q  <= S_RESP;
                    end
                end
                default: if (rsp_ready) state_q <= S_IDLE;
            endcase
        end
    end

    assign keep       = variant_keeps(var_q) && (fault_q == FLT_NONE);
    assign cpl_ready  = (state_q == S_WAIT);
    assign rsp_valid  = (state_q == S_RESP);
    assign rsp_fault  = fault_q;
    assign rsp_wb     = rsp_valid && keep;
    assign rsp_dst    = keep ? dst_q : '0;
    assign rsp_status = keep ? status_q : '0;

    a_r9_send_follows_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> $past(req_valid && req_ready));

    a_r4_fault_skips_write: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid && (rsp_fault != 2'd0)) |-> $past(req_valid && req_ready));

    a_r7_wait_after_burst: assert property (@(posedge clk) disable iff (rst)
        $rose(cpl_ready) |-> $past(wr_valid && wr_ready && wr_last));

    a_r11_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_fault) && $stable(rsp_wb)));

    a_r8_wb_without_fault: assert property (@(posedge clk) disable iff (rst)
        rsp_wb |-> (rsp_fault == 2'd0));
endmodule

// File: tb/test_atomic_line_store.sv
module test_atomic_line_store;
    localparam int TMO = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [15:0]  req_addr = '0;
    logic [511:0] req_data = '0;
    logic         req_memtype = 1'b0;
    logic [1:0]   req_inner = '0, req_outer = '0, req_variant = '0;
    logic [4:0]   req_dst = '0;
    logic         wr_valid, wr_ready = 1'b0;
    logic [15:0]  wr_addr;
    logic [63:0]  wr_data;
    logic         wr_first, wr_last, wr_lock;
    logic         cpl_valid = 1'b0, cpl_ready;
    logic [63:0]  cpl_status = '0;
    logic         rsp_valid, rsp_ready = 1'b0;
    logic [1:0]   rsp_fault;
    logic         rsp_wb;
    logic [4:0]   rsp_dst;
    logic [63:0]  rsp_status;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    atomic_line_store #(.ADDR_W(16), .DST_W(5), .TMO_CYCLES(TMO)) i_atomic_line_store (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_memtype(req_memtype), .req_inner(req_inner),
        .req_outer(req_outer), .req_variant(req_variant), .req_dst(req_dst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_first(wr_first), .wr_last(wr_last), .wr_lock(wr_lock),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_status(cpl_status),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_wb(rsp_wb), .rsp_dst(rsp_dst), .rsp_status(rsp_status)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL R9 watchdog expired: act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] dword(input int s, input int i);
        return {16'hA5C3 ^ 16'(s), 16'(i), 32'(s * 7919 + i * 131)};
    endfunction

    // d = cycle after last beat in which completion is offered; 0 = never
    task automatic run_req(input logic [15:0] addr, input logic mt, input logic [1:0] ci,
                           input logic [1:0] co, input logic [1:0] vr, input logic [4:0] dst,
                           input logic [63:0] st, input int d, input bit stall, input int seed);
        logic [1:0]  efault;
        logic        ekeep;
        logic [63:0] estat;
        logic [63:0] held;
        int it = 0, k = 0, since = 0;
        bit got = 0;
        efault = (addr[5:0] != 6'd0) ? 2'd2 : ((mt && (ci != 0 || co != 0)) ? 2'd1 : 2'd0);
        ekeep  = (efault == 0) && (vr == 2'd1 || vr == 2'd2);
        estat  = ekeep ? ((d == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : st) : 64'd0;

        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_memtype = mt; req_inner = ci;
        req_outer = co; req_variant = vr; req_dst = dst;
        for (int i = 0; i < 8; i++) req_data[i*64 +: 64] = dword(seed, i);
        chk(req_ready == 1'b1, "R9 idle before request", 64'(req_ready), 64'd1);

        while (!got && it < 400) begin
            @(negedge clk);
            it++;
            req_valid = 1'b0;
            cpl_valid = 1'b0;
            if (k == 8) since++;
            wr_ready = stall ? (it % 3 != 0) : 1'b1;
            if (it == 1) chk(req_ready == 1'b0, "R9 busy after accept", 64'(req_ready), 64'd0);
            if (rsp_valid) got = 1;
            else begin
                if (k == 8 && d != 0 && since == d) begin
                    cpl_valid = 1'b1; cpl_status = st;
                    chk(cpl_ready == 1'b1, "R7 completion accepted", 64'(cpl_ready), 64'd1);
                end
                if (wr_valid && wr_ready) begin
                    if (efault != 0 || k >= 8) begin
                        chk(1'b0, "R3 R4 unexpected beat", 64'(k), 64'(efault == 0 ? 8 : 0));
                    end else begin
                        chk(wr_addr == {addr[15:6], 3'(k), 3'b000}, "R2 beat address", 64'(wr_addr),
                            64'({addr[15:6], 3'(k), 3'b000}));
                        chk(wr_data == dword(seed, k), "R2 beat data", wr_data, dword(seed, k));
                        chk(wr_first == (k == 0) && wr_last == (k == 7) && wr_lock,
                            "R2 burst markers", 64'({wr_first, wr_last, wr_lock}),
                            64'({k == 0, k == 7, 1'b1}));
                    end
                    k++;
                end
            end
        end
        cpl_valid = 1'b0;
        chk(got, "R7 response arrives", 64'(got), 64'd1);
        if (efault != 0) begin
            chk(k == 0, "R4 R6 no beat on fault", 64'(k), 64'd0);
            chk(it == 1, "R4 R6 fault timing", 64'(it), 64'd1);
        end else begin
            chk(k == 8, "R2 beat count", 64'(k), 64'd8);
            chk(since == ((d == 0) ? TMO + 1 : d + 1), "R10 R7 response cycle",
                64'(since), 64'((d == 0) ? TMO + 1 : d + 1));
        end
        chk(rsp_fault == efault, "R4 R5 R6 fault code", 64'(rsp_fault), 64'(efault));
        chk(rsp_wb == ekeep, "R8 write-back flag", 64'(rsp_wb), 64'(ekeep));
        chk(rsp_dst == (ekeep ? dst : 5'd0), "R8 destination", 64'(rsp_dst), 64'(ekeep ? dst : 5'd0));
        chk(rsp_status == estat, "R7 R10 status", rsp_status, estat);
        held = rsp_status;
        @(negedge clk);
        chk(rsp_valid && rsp_status == held && rsp_wb == ekeep, "R11 response held",
            rsp_status, held);
        chk(req_ready == 1'b0, "R9 busy while response pending", 64'(req_ready), 64'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R9 ready after response", 64'({rsp_valid, req_ready}), 64'b01);
    endtask

    initial begin
        logic [63:0] pats [4];
        int n;
        pats[0] = 64'd0;
        pats[1] = 64'd1;
        pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[3] = 64'hDEAD_BEEF_0000_0042;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(!wr_valid && !cpl_ready && !rsp_valid, "R1 outputs idle after reset",
            64'({wr_valid, cpl_ready, rsp_valid}), 64'd0);

        n = 0;
        for (int mt = 0; mt < 2; mt++)
            for (int ci = 0; ci < 4; ci++)
                for (int co = 0; co < 4; co++)
                    for (int vr = 0; vr < 4; vr++) begin
                        run_req({10'(n + 3), 6'd0}, 1'(mt), 2'(ci), 2'(co), 2'(vr), 5'(n),
                                pats[n % 4], 1 + (n % 3), n[0], n);
                        n++;
                    end

        // R6 misaligned, alone and with a cacheable normal attribute
        run_req(16'h0048, 1'b1, 2'd3, 2'd0, 2'd1, 5'd7, 64'd5, 1, 1'b0, 900);
        run_req(16'h0281, 1'b0, 2'd0, 2'd0, 2'd2, 5'd9, 64'd5, 1, 1'b0, 901);
        // R10 completion in the final allowed cycle, and none at all
        run_req(16'h1C0, 1'b1, 2'd0, 2'd0, 2'd2, 5'd3, 64'd5, TMO, 1'b1, 902);
        run_req(16'h200, 1'b0, 2'd2, 2'd1, 2'd1, 5'd4, 64'd5, 0, 1'b0, 903);
        run_req(16'h240, 1'b0, 2'd0, 2'd0, 2'd0, 5'd4, 64'd5, 0, 1'b1, 904);
        run_req(16'h280, 1'b1, 2'd0, 2'd0, 2'd3, 5'd6, 64'd1, 2, 1'b0, 905);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule